// File: doc/BRIEF.md
# Interrupt Request Latch with Per-Line Trigger Mode

This block turns a group of raw interrupt request wires into a vector of pending requests that a priority stage further downstream can consume. Each wire first passes through a short synchronizer chain. A register then holds the last synchronized level of each line, and each line keeps one pending bit. A per-line trigger-mode bit decides how that pending bit behaves. A line in level mode shows its input in the pending bit at every cycle. A line in edge mode sets its pending bit on a low-to-high transition and holds it until the line is acknowledged.

The trigger-mode register is written as a whole word. The written value is ANDed with a mask fixed per instance by a parameter, so lines whose bit is clear in the mask are always edge-sensitive. Two typical instances use masks 8'hF8 and 8'hDE. The acknowledge port names a single line by index. It clears that line's pending bit only when the line is edge-sensitive. A level-sensitive request stays pending until its input drops. The pending vector and the trigger-mode readback are both register outputs.

Top module: `irq_req_latch`

## Requirements
- R1: A synchronous active-high reset clears the pending vector, the stored previous levels and the trigger-mode register, so pending reads 0 and the mode readback reads 0 after reset.
- R2: A write with mode_wr_en stores mode_wr_data AND ALLOW_MASK (default 8'hF8). The value appears on mode_rb one clock later and holds while no write occurs. Bit n set means line n is level-sensitive; bit n clear means edge-sensitive.
- R3: For a level-sensitive line, the pending bit follows the input. A change on irq_in is visible on pending after exactly SYNC_STAGES+1 rising edges (3 by default) and not earlier.
- R4: For an edge-sensitive line, a synchronized low-to-high transition sets the pending bit.
- R5: For an edge-sensitive line, a falling input leaves the pending bit set. An input that stays high does not set the bit again after it has been cleared.
- R6: An acknowledge (ack_valid with ack_line = n) clears pending bit n on the next edge when line n is edge-sensitive. Other lines are unaffected.
- R7: An acknowledge of a level-sensitive line has no effect on its pending bit.
- R8: When an acknowledge and a new rising edge hit the same edge-sensitive line in the same cycle, the rising edge wins and the pending bit stays set.
- R9: After an edge-sensitive line has been acknowledged, a new low-then-high transition sets its pending bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Asynchronous interrupt request lines |
| mode_wr_en | input | 1 | Trigger-mode register write strobe |
| mode_wr_data | input | N_LINES | Trigger-mode write value (1 = level) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | clog2(N_LINES) | Index of the acknowledged line |
| pending | output | N_LINES | Latched pending requests |
| mode_rb | output | N_LINES | Trigger-mode register readback |

## Verification
All 256 trigger-mode write values are swept, which shows that the allow-mask gates each bit independently. A stepped sequence of 40 input patterns is then applied under three mode settings and compared with an arithmetic model. Level lines separate from edge lines there: level bits track the current pattern, while edge bits accumulate rising transitions. Directed sequences check the exact synchronizer latency, falling edges that must not clear a bit, held-high inputs that must not re-arm a line, acknowledges of level lines that must be ignored, and the same-cycle race between an acknowledge and a rising edge.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  // Trigger mode encoding: register bit value per line.
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

endpackage

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
  parameter int N_LINES     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] din,
  output logic [N_LINES-1:0] dout
);

  logic [N_LINES-1:0] stg [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < SYNC_STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[SYNC_STAGES-1];

endmodule

// File: rtl/irq_trig_mode_reg.sv
module irq_trig_mode_reg #(
  parameter int                 N_LINES    = 8,
  parameter logic [N_LINES-1:0] ALLOW_MASK = 8'hF8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [N_LINES-1:0] wr_data,
  output logic [N_LINES-1:0] mode_q
);

  always_ff @(posedge clk) begin
    if (rst)        mode_q <= '0;
    else if (wr_en) mode_q <= wr_data & ALLOW_MASK;
  end

endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_latch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl,
  input  trig_mode_e mode,
  input  logic       ack_hit,
  output logic       pend_q,
  output logic       prev_q
);

  logic rise;
  assign rise = lvl & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      case (mode)
        TRIG_LEVEL: pend_q <= lvl;
        default: begin
          if (rise)         pend_q <= 1'b1;
          else if (ack_hit) pend_q <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter int                 N_LINES     = 8,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [N_LINES-1:0] ALLOW_MASK  = 8'hF8,
  localparam int                LINE_W      = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               mode_wr_en,
  input  logic [N_LINES-1:0] mode_wr_data,
  input  logic               ack_valid,
  input  logic [LINE_W-1:0]  ack_line,
  output logic [N_LINES-1:0] pending,
  output logic [N_LINES-1:0] mode_rb
);

  logic [N_LINES-1:0] lvl_sync;
  logic [N_LINES-1:0] lvl_prev;
  logic [N_LINES-1:0] ack_hit;

  irq_in_sync #(
    .N_LINES     (N_LINES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (irq_in),
    .dout (lvl_sync)
  );

  irq_trig_mode_reg #(
    .N_LINES    (N_LINES),
    .ALLOW_MASK (ALLOW_MASK)
  ) u_mode (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (mode_wr_en),
    .wr_data (mode_wr_data),
    .mode_q  (mode_rb)
  );

  always_comb begin
    ack_hit = '0;
    if (ack_valid) ack_hit[ack_line] = 1'b1;
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    irq_line_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .lvl     (lvl_sync[g]),
      .mode    (trig_mode_e'(mode_rb[g])),
      .ack_hit (ack_hit[g]),
      .pend_q  (pending[g]),
      .prev_q  (lvl_prev[g])
    );
  end

endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
  parameter int                 N_LINES    = 8,
  parameter logic [N_LINES-1:0] ALLOW_MASK = 8'hF8,
  parameter int                 LINE_W     = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               mode_wr_en,
  input logic [N_LINES-1:0] mode_wr_data,
  input logic               ack_valid,
  input logic [LINE_W-1:0]  ack_line,
  input logic [N_LINES-1:0] pending,
  input logic [N_LINES-1:0] mode_rb,
  input logic [N_LINES-1:0] lvl_sync,
  input logic [N_LINES-1:0] lvl_prev
);

  // R1: state cleared by reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pending == '0 && mode_rb == '0));

  // R2: masked write, then hold
  a_r2_masked_write: assert property (@(posedge clk) disable iff (rst)
    mode_wr_en |=> mode_rb == ($past(mode_wr_data) & ALLOW_MASK));
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !mode_wr_en |=> $stable(mode_rb));

  for (genvar i = 0; i < N_LINES; i++) begin : g_chk
    // R3 and R7: a level line tracks its synchronized input
    a_r3_level_follow: assert property (@(posedge clk) disable iff (rst)
      $past(mode_rb[i]) |-> pending[i] == $past(lvl_sync[i]));
    // R4 and R8: a rising edge always sets the bit
    a_r4_edge_set: assert property (@(posedge clk) disable iff (rst)
      (!$past(mode_rb[i]) && $past(lvl_sync[i]) && !$past(lvl_prev[i])) |-> pending[i]);
    // R5: without an acknowledge an edge line stays pending
    a_r5_edge_hold: assert property (@(posedge clk) disable iff (rst)
      (!$past(mode_rb[i]) && $past(pending[i]) &&
       !($past(ack_valid) && $past(ack_line) == LINE_W'(i))) |-> pending[i]);
    // R6: an acknowledge without a rising edge clears an edge line
    a_r6_ack_clear: assert property (@(posedge clk) disable iff (rst)
      (!$past(mode_rb[i]) && $past(ack_valid) && $past(ack_line) == LINE_W'(i) &&
       !($past(lvl_sync[i]) && !$past(lvl_prev[i]))) |-> !pending[i]);
  end

endmodule

bind irq_req_latch irq_req_latch_chk #(
  .N_LINES    (N_LINES),
  .ALLOW_MASK (ALLOW_MASK),
  .LINE_W     (LINE_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_wr_en   (mode_wr_en),
  .mode_wr_data (mode_wr_data),
  .ack_valid    (ack_valid),
  .ack_line     (ack_line),
  .pending      (pending),
  .mode_rb      (mode_rb),
  .lvl_sync     (lvl_sync),
  .lvl_prev     (lvl_prev)
);

// File: tb/irq_req_latch_tb.sv
module irq_req_latch_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ALLOW = 8'hF8;
  localparam int SETTLE = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       mode_wr_en = 1'b0;
  logic [7:0] mode_wr_data = '0;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_line = '0;
  logic [7:0] pending;
  logic [7:0] mode_rb;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_req_latch #(
    .N_LINES     (8),
    .SYNC_STAGES (2),
    .ALLOW_MASK  (ALLOW)
  ) u_dut (
    .clk          (clk),
    .rst          (rst),
    .irq_in       (irq_in),
    .mode_wr_en   (mode_wr_en),
    .mode_wr_data (mode_wr_data),
    .ack_valid    (ack_valid),
    .ack_line     (ack_line),
    .pending      (pending),
    .mode_rb      (mode_rb)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    irq_in = '0;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic write_mode(input logic [7:0] v);
    mode_wr_en = 1'b1;
    mode_wr_data = v;
    tick(1);
    mode_wr_en = 1'b0;
  endtask

  task automatic ack(input logic [2:0] l);
    ack_valid = 1'b1;
    ack_line = l;
    tick(1);
    ack_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] exp_p;
    logic [7:0] prev_p;
    logic [7:0] m;
    logic [7:0] p;
    logic [7:0] modes [3];
    modes[0] = 8'h00; modes[1] = 8'hFF; modes[2] = 8'hA9;

    do_reset();
    chk("R1 pending after reset", pending, 8'h00);
    chk("R1 mode after reset", mode_rb, 8'h00);

    // R2: every write value is masked
    for (int v = 0; v < 256; v++) begin
      write_mode(8'(v));
      chk("R2 masked readback", mode_rb, 8'(v) & ALLOW);
    end
    tick(4);
    chk("R2 readback holds", mode_rb, 8'hF8);

    // R3: exact latency on level line 3
    irq_in[3] = 1'b1;
    tick(2);
    chk("R3 not yet visible", pending, 8'h00);
    tick(1);
    chk("R3 visible after 3 edges", pending, 8'h08);
    irq_in[3] = 1'b0;
    tick(SETTLE);
    chk("R3 level cleared on low", pending, 8'h00);

    // R4/R5/R6/R9 on edge lines 0 and 1
    irq_in[1:0] = 2'b11;
    tick(SETTLE);
    chk("R4 rising sets", pending, 8'h03);
    irq_in[1:0] = 2'b00;
    tick(SETTLE);
    chk("R5 falling keeps", pending, 8'h03);
    ack(3'd0);
    chk("R6 ack clears only line 0", pending, 8'h02);
    ack(3'd1);
    chk("R6 ack clears line 1", pending, 8'h00);
    irq_in[0] = 1'b1;
    tick(SETTLE);
    chk("R9 rearm after ack", pending, 8'h01);
    ack(3'd0);
    chk("R6 ack while high", pending, 8'h00);
    tick(SETTLE);
    chk("R5 held high no reset", pending, 8'h00);
    irq_in[0] = 1'b0;
    tick(SETTLE);
    irq_in[0] = 1'b1;
    tick(SETTLE);
    chk("R9 new edge sets again", pending, 8'h01);
    ack(3'd0);
    irq_in[0] = 1'b0;
    tick(SETTLE);

    // R7: acknowledge of level line 5 ignored
    irq_in[5] = 1'b1;
    tick(SETTLE);
    chk("R7 level pending", pending, 8'h20);
    ack(3'd5);
    chk("R7 ack on level ignored", pending, 8'h20);
    tick(1);
    chk("R7 still pending", pending, 8'h20);
    irq_in[5] = 1'b0;
    tick(SETTLE);

    // R8: acknowledge and rising edge together on edge line 2
    irq_in[2] = 1'b1;
    tick(SETTLE);
    irq_in[2] = 1'b0;
    tick(SETTLE);
    chk("R8 setup pending", pending, 8'h04);
    irq_in[2] = 1'b1;
    tick(2);
    ack(3'd2);
    chk("R8 edge wins over ack", pending, 8'h04);
    ack(3'd2);
    chk("R8 later ack clears", pending, 8'h00);

    // R1: reset mid-operation
    irq_in = 8'hFF;
    tick(SETTLE);
    do_reset();
    chk("R1 pending after mid reset", pending, 8'h00);
    chk("R1 mode after mid reset", mode_rb, 8'h00);

    // Pattern sweep against arithmetic model (R3, R4, R5, R6, R7)
    for (int mi = 0; mi < 3; mi++) begin
      do_reset();
      write_mode(modes[mi]);
      m = modes[mi] & ALLOW;
      exp_p = '0;
      prev_p = '0;
      for (int k = 0; k < 40; k++) begin
        p = 8'((k * 37 + mi * 11 + 5) % 256);
        irq_in = p;
        tick(SETTLE);
        exp_p = (p & m) | ((exp_p | (p & ~prev_p)) & ~m);
        prev_p = p;
        chk("R4 R3 sweep pattern", pending, exp_p);
      end
      irq_in = '0;
      tick(SETTLE);
      exp_p = exp_p & ~m;
      chk("R5 sweep after release", pending, exp_p);
      for (int l = 0; l < 8; l++) begin
        ack(3'(l));
        if (!m[l]) exp_p[l] = 1'b0;
        chk("R6 R7 sweep ack", pending, exp_p);
      end
    end

    finish_run();
  end

endmodule